// File: doc/BRIEF.md
# DMA Event and Channel Control Register Block

This block is the shared status and control register file of a multi-channel DMA engine. Each channel reports three kinds of event: a descriptor finished, the peripheral terminated the transfer early, or the bus returned an error. The block latches these events as sticky flags, combines them with per-channel interrupt enables, and drives one interrupt line per channel. Software services a channel by reading the flags and clearing only that channel's bits.

The same register file holds the per-channel freeze levels and the per-channel reset requests. A reset request is not sent to the channel at once. It waits while that channel reports its read-flush state, because a reset issued in that state can wedge the channel. A cycle counter bounds the wait, so a channel stuck in flush is still reset after a fixed number of cycles.

Every register is reached at three addresses: a plain write at the base, a set-bits write at base+0x4 and a clear-bits write at base+0x8. Reads at any of the three return the register. Each channel's current state code can also be read back from its own bank window.

Top module: `dma_evt_ctrl`

## Requirements
- R1: After reset, the completion register (0x00), error register (0x10) and control register (0x20) read zero, and `ch_irq`, `ch_freeze` and `ch_reset` are all zero.
- R2: A `ch_done[n]` pulse sets bit n of the completion register. Bits 16+n of that register are the interrupt enables, and `ch_irq[n]` is high when completion bit n and enable bit 16+n are both set.
- R3: In the error register, `ch_term[n]` without `ch_done[n]` sets only bit n (termination). `ch_buserr[n]` sets bit n and bit 16+n (bus error). `ch_term[n]` in the same cycle as `ch_done[n]` sets no error bit. Error bit n drives `ch_irq[n]` whatever the enables hold.
- R4: A write to base+0x4 ORs the data into the register. A write to base+0x8 clears exactly the bits written as one and leaves every other bit as it was.
- R5: An event that arrives in the same cycle as a clear-bits write to its flag leaves the flag set.
- R6: Control register bits 15:0 drive `ch_freeze` directly, and they follow plain, set-bits and clear-bits writes.
- R7: Writing one to control bit 16+n, when channel n's state is not 0x8, gives a `ch_reset[n]` pulse exactly one cycle wide in the cycle after the write, and bit 16+n reads back as zero from then on.
- R8: While `ch_state` of channel n equals 0x8 (read flush), a pending reset of channel n is held and bit 16+n stays set. The pulse follows one cycle after the state changes. A flush state on a different channel does not hold it back.
- R9: If the channel stays in state 0x8, the reset pulse still comes, GUARD_CYC+1 cycles after the write.
- R10: A read at 0x100 + n*0x70 returns channel n's 4-bit state code in bits 3:0, with the upper bits zero.
- R11: A plain write replaces the whole register, the enable half included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ch_done | input | NCH | Per-channel completion event pulses |
| ch_term | input | NCH | Per-channel termination event pulses |
| ch_buserr | input | NCH | Per-channel bus-error event pulses |
| ch_state | input | NCH*STATE_W | Per-channel state codes, channel n at bits n*STATE_W upward |
| ch_irq | output | NCH | Per-channel interrupt lines |
| ch_freeze | output | NCH | Per-channel freeze levels |
| ch_reset | output | NCH | Per-channel one-cycle reset pulses |

## Verification
Properties are checked on every cycle: a completion or bus-error event is captured on the next edge, the freeze outputs move only on a control write, a reset pulse never lasts two cycles, and a reset never fires while the channel is flushing and the guard counter is below its limit. The bench scenarios cover what these properties leave out: the exact encodings of termination against bus error, the suppression of termination when completion arrives with it, the isolation between channels under the clear alias, the exact cycle of release after a flush ends, the timeout length, and the bank address arithmetic.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
   // write flavour picked by address bits 3:2
   typedef enum logic [1:0] {
      WK_PLAIN = 2'd0,
      WK_SET   = 2'd1,
      WK_CLR   = 2'd2,
      WK_NONE  = 2'd3
   } wkind_e;

   localparam int REG_W = 32;
   localparam int HALF  = 16;

   // register slots decoded from address bits above 3:0
   localparam int SLOT_CMP = 0;
   localparam int SLOT_ERR = 1;
   localparam int SLOT_CTL = 2;

   // per-channel state windows
   localparam int unsigned BANK_BASE   = 32'h100;
   localparam int unsigned BANK_STRIDE = 32'h70;
endpackage

// File: rtl/dma_evt_dec.sv
module dma_evt_dec
   import dma_evt_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NCH    = 16,
   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output wkind_e            kind,
   output logic              sel_cmp,
   output logic              sel_err,
   output logic              sel_ctl,
   output logic              bank_hit,
   output logic [IDX_W-1:0]  bank_idx
);
   localparam int SLOT_W = ADDR_W - 4;

   logic              aligned;
   logic [SLOT_W-1:0] slot;

   assign aligned = (addr[1:0] == 2'b00);
   assign slot    = addr[ADDR_W-1:4];
   assign kind    = wkind_e'(addr[3:2]);
   assign sel_cmp = aligned && (slot == SLOT_W'(SLOT_CMP));
   assign sel_err = aligned && (slot == SLOT_W'(SLOT_ERR));
   assign sel_ctl = aligned && (slot == SLOT_W'(SLOT_CTL));

   always_comb begin
      bank_hit = 1'b0;
      bank_idx = '0;
      for (int n = 0; n < NCH; n++) begin
         if (addr == ADDR_W'(BANK_BASE + BANK_STRIDE * n)) begin
            bank_hit = 1'b1;
            bank_idx = IDX_W'(n);
         end
      end
   end
endmodule

// File: rtl/dma_evt_alias.sv
module dma_evt_alias
   import dma_evt_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         hit,
   input  wkind_e       kind,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] nxt
);
   always_comb begin
      nxt = cur;
      if (hit) begin
         unique case (kind)
            WK_PLAIN: nxt = wdata;
            WK_SET:   nxt = cur | wdata;
            WK_CLR:   nxt = cur & ~wdata;
            WK_NONE:  nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/dma_evt_rst_guard.sv
module dma_evt_rst_guard #(
   parameter int                  STATE_W    = 4,
   parameter logic [STATE_W-1:0]  FLUSH_CODE = STATE_W'(8),
   parameter int                  GUARD_CYC  = 5000,
   localparam int                 CNT_W      = $clog2(GUARD_CYC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_nxt,
   input  logic [STATE_W-1:0] state,
   output logic               pend_q,
   output logic               rst_pulse
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GUARD_CYC);

   logic             in_flush;
   logic             fire;
   logic [CNT_W-1:0] cnt_q;

   assign in_flush = (state == FLUSH_CODE);
   assign fire     = pend_q && (!in_flush || cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         rst_pulse <= 1'b0;
         cnt_q     <= '0;
      end else begin
         pend_q    <= sw_nxt && !fire;
         rst_pulse <= fire;
         if (!pend_q || !in_flush || fire)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   // R8
   flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && in_flush && cnt_q != LIMIT) |=> !rst_pulse);

   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);
endmodule

// File: rtl/dma_evt_ctrl.sv
module dma_evt_ctrl
   import dma_evt_pkg::*;
#(
   parameter int                 NCH        = 16,
   parameter int                 ADDR_W     = 12,
   parameter int                 STATE_W    = 4,
   parameter logic [STATE_W-1:0] FLUSH_CODE = STATE_W'(8),
   parameter int                 GUARD_CYC  = 5000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic [NCH-1:0]         ch_done,
   input  logic [NCH-1:0]         ch_term,
   input  logic [NCH-1:0]         ch_buserr,
   input  logic [NCH*STATE_W-1:0] ch_state,
   output logic [NCH-1:0]         ch_irq,
   output logic [NCH-1:0]         ch_freeze,
   output logic [NCH-1:0]         ch_reset
);
   localparam int          IDX_W     = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [31:0] CH_MASK   = (32'h1 << NCH) - 32'h1;
   localparam logic [31:0] FULL_MASK = CH_MASK | (CH_MASK << HALF);

   if (NCH < 2 || NCH > HALF) begin : bad_nch
      $error("NCH must lie in 2..16");
   end
   if (STATE_W < 1 || STATE_W > REG_W) begin : bad_state_w
      $error("STATE_W out of range");
   end
   if (GUARD_CYC < 1) begin : bad_guard
      $error("GUARD_CYC must be at least 1");
   end
   if (ADDR_W < 12) begin : bad_addr_w
      $error("ADDR_W too small for the bank windows");
   end

   wkind_e           kind;
   logic             sel_cmp, sel_err, sel_ctl, bank_hit;
   logic [IDX_W-1:0] bank_idx;

   dma_evt_dec #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
      .addr     (reg_addr),
      .kind     (kind),
      .sel_cmp  (sel_cmp),
      .sel_err  (sel_err),
      .sel_ctl  (sel_ctl),
      .bank_hit (bank_hit),
      .bank_idx (bank_idx)
   );

   logic [31:0]    cmp_q, err_q, ctl_cur;
   logic [31:0]    cmp_sw, err_sw, ctl_sw;
   logic [NCH-1:0] freeze_q, pend;
   logic [NCH-1:0] err_lo_set;

   assign ctl_cur = 32'(freeze_q) | (32'(pend) << HALF);

   dma_evt_alias #(.W(REG_W)) u_cmp_alias (
      .hit(reg_we && sel_cmp), .kind(kind), .cur(cmp_q), .wdata(reg_wdata), .nxt(cmp_sw));
   dma_evt_alias #(.W(REG_W)) u_err_alias (
      .hit(reg_we && sel_err), .kind(kind), .cur(err_q), .wdata(reg_wdata), .nxt(err_sw));
   dma_evt_alias #(.W(REG_W)) u_ctl_alias (
      .hit(reg_we && sel_ctl), .kind(kind), .cur(ctl_cur), .wdata(reg_wdata), .nxt(ctl_sw));

   // termination alongside completion is a normal end, not an error
   assign err_lo_set = ch_buserr | (ch_term & ~ch_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q    <= '0;
         err_q    <= '0;
         freeze_q <= '0;
      end else begin
         cmp_q    <= (cmp_sw & FULL_MASK) | 32'(ch_done);
         err_q    <= (err_sw & FULL_MASK) | 32'(err_lo_set) | (32'(ch_buserr) << HALF);
         freeze_q <= ctl_sw[NCH-1:0];
      end
   end

   assign ch_freeze = freeze_q;
   assign ch_irq    = (cmp_q[NCH-1:0] & cmp_q[HALF +: NCH]) | err_q[NCH-1:0];

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      dma_evt_rst_guard #(
         .STATE_W    (STATE_W),
         .FLUSH_CODE (FLUSH_CODE),
         .GUARD_CYC  (GUARD_CYC)
      ) u_guard (
         .clk       (clk),
         .rst_n     (rst_n),
         .sw_nxt    (ctl_sw[HALF + n]),
         .state     (ch_state[n*STATE_W +: STATE_W]),
         .pend_q    (pend[n]),
         .rst_pulse (ch_reset[n])
      );

      // R2
      done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_done[n] |=> cmp_q[n]);

      // R3
      buserr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_buserr[n] |=> (err_q[n] && err_q[HALF + n]));
   end

   // R6
   freeze_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && sel_ctl) |=> $stable(ch_freeze));

   always_comb begin
      reg_rdata = '0;
      if (sel_cmp)
         reg_rdata = cmp_q;
      else if (sel_err)
         reg_rdata = err_q;
      else if (sel_ctl)
         reg_rdata = ctl_cur;
      else if (bank_hit)
         reg_rdata = 32'(ch_state[bank_idx*STATE_W +: STATE_W]);
   end
endmodule

// File: tb/dma_evt_ctrl_test.sv
module dma_evt_ctrl_test;
   localparam int NCH = 16;
   localparam int SW  = 4;
   localparam int G   = 8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            reg_we;
   logic [11:0]     reg_addr;
   logic [31:0]     reg_wdata, reg_rdata;
   logic [NCH-1:0]  ch_done, ch_term, ch_buserr;
   logic [NCH*SW-1:0] ch_state;
   logic [NCH-1:0]  ch_irq, ch_freeze, ch_reset;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   dma_evt_ctrl #(.NCH(NCH), .ADDR_W(12), .STATE_W(SW), .GUARD_CYC(G)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_done(ch_done),
      .ch_term(ch_term), .ch_buserr(ch_buserr), .ch_state(ch_state),
      .ch_irq(ch_irq), .ch_freeze(ch_freeze), .ch_reset(ch_reset));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] tm,
                        input logic [NCH-1:0] be);
      @(negedge clk);
      ch_done = dn; ch_term = tm; ch_buserr = be;
      @(negedge clk);
      ch_done = '0; ch_term = '0; ch_buserr = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [31:0] exp_cmp;
      int first;
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      ch_done = '0; ch_term = '0; ch_buserr = '0; ch_state = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(12'h000, r); check("R1 cmp", r, 0);
      rd(12'h010, r); check("R1 err", r, 0);
      rd(12'h020, r); check("R1 ctl", r, 0);
      check("R1 outputs", {ch_irq, ch_freeze}, 0);
      check("R1 reset out", 32'(ch_reset), 0);

      // R2 completion capture, accumulating over all channels
      exp_cmp = 0;
      for (int n = 0; n < NCH; n++) begin
         pulse(NCH'(1) << n, '0, '0);
         exp_cmp |= 32'h1 << n;
         rd(12'h000, r); check("R2 done flag", r, exp_cmp);
      end
      check("R2 irq gated by enables", 32'(ch_irq), 0);
      wr(12'h004, 32'h5555_0000);
      exp_cmp |= 32'h5555_0000;
      check("R2 irq enabled", 32'(ch_irq), 32'h5555);

      // R4 clear alias, one channel at a time
      for (int n = 0; n < NCH; n++) begin
         wr(12'h008, 32'h1 << n);
         exp_cmp &= ~(32'h1 << n);
         rd(12'h004, r); check("R4 cmp clear", r, exp_cmp);
      end
      check("R4 irq after clears", 32'(ch_irq), 0);

      // R11 plain write replaces enables too
      wr(12'h000, 32'h0000_0003);
      rd(12'h000, r); check("R11 plain", r, 32'h0000_0003);
      check("R11 irq no enables", 32'(ch_irq), 0);
      wr(12'h000, 32'h0);

      // R3 error encodings per channel
      for (int n = 0; n < NCH; n++) begin
         pulse('0, NCH'(1) << n, '0);
         rd(12'h010, r); check("R3 termination", r, 32'h1 << n);
         check("R3 err irq", 32'(ch_irq), 32'h1 << n);
         wr(12'h018, 32'hFFFF);
         pulse('0, '0, NCH'(1) << n);
         rd(12'h010, r); check("R3 bus error", r, (32'h1 << n) | (32'h1 << (16 + n)));
         wr(12'h018, 32'h1 << n);
         rd(12'h010, r); check("R4 err clear isolates status", r, 32'h1 << (16 + n));
         wr(12'h010, 32'h0);
         pulse(NCH'(1) << n, NCH'(1) << n, '0);
         rd(12'h010, r); check("R3 term with done", r, 0);
         rd(12'h000, r); check("R3 done still set", r, 32'h1 << n);
         wr(12'h000, 32'h0);
      end

      // R5 event beats simultaneous clear
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 12'h008; reg_wdata = 32'h8; ch_done = NCH'(8);
      @(negedge clk);
      reg_we = 1'b0; ch_done = '0;
      rd(12'h000, r); check("R5 event wins", r, 32'h8);
      wr(12'h000, 32'h0);

      // R6 freeze through all aliases
      wr(12'h020, 32'hA5A5);
      check("R6 plain", 32'(ch_freeze), 32'hA5A5);
      wr(12'h024, 32'h0F00);
      check("R6 set", 32'(ch_freeze), 32'hAFA5);
      wr(12'h028, 32'h00A5);
      check("R6 clr", 32'(ch_freeze), 32'hAF00);
      rd(12'h020, r); check("R6 readback", r, 32'hAF00);

      // R7 immediate reset pulse on every channel
      for (int n = 0; n < NCH; n++) begin
         wr(12'h024, 32'h1 << (16 + n));
         check("R7 no pulse yet", 32'(ch_reset), 0);
         rd(12'h020, r); check("R7 pending", r, 32'hAF00 | (32'h1 << (16 + n)));
         @(negedge clk);
         check("R7 pulse", 32'(ch_reset), 32'h1 << n);
         rd(12'h020, r); check("R7 self clear", r, 32'hAF00);
         @(negedge clk);
         check("R7 one cycle", 32'(ch_reset), 0);
      end

      // R8 flush on channel 6 does not delay channel 7
      ch_state[6*SW +: SW] = 4'h8;
      wr(12'h024, 32'h1 << 23);
      @(negedge clk);
      check("R8 other channel free", 32'(ch_reset), 32'h1 << 7);
      ch_state = '0;

      // R8 held during flush, released one cycle after leaving
      ch_state[5*SW +: SW] = 4'h8;
      wr(12'h024, 32'h1 << 21);
      for (int j = 1; j <= 3; j++) begin
         @(negedge clk);
         check("R8 held", 32'(ch_reset), 0);
      end
      rd(12'h020, r); check("R8 pending kept", r, 32'hAF00 | (32'h1 << 21));
      ch_state[5*SW +: SW] = 4'h3;
      @(negedge clk);
      check("R8 released", 32'(ch_reset), 32'h1 << 5);
      ch_state = '0;
      @(negedge clk);

      // R9 timeout while flush persists
      ch_state[9*SW +: SW] = 4'h8;
      wr(12'h024, 32'h1 << 25);
      first = -1;
      for (int j = 1; j <= G + 6; j++) begin
         @(negedge clk);
         if (first < 0 && ch_reset != 0) begin
            first = j;
            check("R9 which channel", 32'(ch_reset), 32'h1 << 9);
         end
      end
      check("R9 timeout cycle", 32'(first), 32'(G + 1));
      ch_state = '0;

      // R10 per-channel state windows
      for (int n = 0; n < NCH; n++) ch_state[n*SW +: SW] = SW'((n * 3 + 1) & 15);
      for (int n = 0; n < NCH; n++) begin
         rd(12'(32'h100 + n * 32'h70), r);
         check("R10 state window", r, 32'((n * 3 + 1) & 15));
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule